// File: doc/BRIEF.md
# Partial-Width Aliased Register File

This block holds sixteen 64-bit general-purpose registers and lets each one be read and written as an 8-, 16-, 32- or 64-bit view. A 2-bit size code chooses the width. A separate extension flag changes how byte indices decode and allows the 64-bit view and the upper eight registers. There are two combinational read ports and one synchronous write port. Each read port returns its selected view zero-extended to 64 bits.

Writes of 32 bits clear the upper half of the destination. Writes of 8 and 16 bits merge into the old contents. The block records such merges for each register. When a later read asks for a wider view than the narrowest slice still outstanding, the block raises a stall for one cycle. During that cycle the register counts as merged, so the same read held for one more clock no longer stalls.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and clears all outstanding-merge state. After reset, no read stalls.
- R2: Size codes are 00 = 8 bits, 01 = 16 bits (the operand-size-override width), 10 = 32 bits (the default width) and 11 = 64 bits. Code 11 without the extension flag acts as code 10 on both reads and writes.
- R3: For an 8-bit access without the extension flag, index bit 2 = 0 selects bits 7:0 of register idx[1:0], and bit 2 = 1 selects bits 15:8 of register idx[1:0]. Index bit 3 is ignored.
- R4: For an 8-bit access with the extension flag, the full 4-bit index selects bits 7:0 of that register (0 to 15). No high byte can be reached in this mode.
- R5: For 16-, 32- and 64-bit accesses, the register is idx[2:0] without the extension flag and the full idx with it.
- R6: A 32-bit write stores data[31:0] into bits 31:0 and clears bits 63:32. A 64-bit write stores all 64 bits.
- R7: 8- and 16-bit writes change only the addressed slice. Every other bit of the register keeps its old value.
- R8: Every read returns its slice in the low bits of the port, with all bits above the slice at zero.
- R9: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: After an 8- or 16-bit write, a read of that register wider than the narrowest outstanding partial slice raises `stall` in that cycle. If the read is held across that clock edge, `stall` is low in the next cycle.
- R11: A 32- or 64-bit write clears the register's outstanding-merge state. A read no wider than the outstanding slice never stalls.
- R12: The two read ports decode and return data independently. A stall caused by either port raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 4 | Read port 0 register/byte index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_ext | input | 1 | Read port 0 extension flag |
| rd0_data | output | 64 | Read port 0 zero-extended data |
| rd1_idx | input | 4 | Read port 1 register/byte index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_ext | input | 1 | Read port 1 extension flag |
| rd1_data | output | 64 | Read port 1 zero-extended data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register/byte index |
| wr_size | input | 2 | Write size code |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data (low bits used for narrow sizes) |
| stall | output | 1 | One-cycle merge stall request |

## Verification
Read data and `stall` are combinational, so they are due in the same cycle that the read inputs are applied. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. A write is due one rising edge after `wr_en` is applied. The bypass check therefore samples the old value before that edge and the new value just after it. Each read check holds its inputs across exactly one rising edge before parking the port. This makes the clearing of the merge state after a stalled read land at a known edge, and the next held read is expected not to stall.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_D = 2'b11
  } opsz_t;
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_rf_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic            ext,
  output logic [IDXW-1:0] reg_sel,
  output opsz_t           eff_size,
  output logic            hi_byte
);
  always_comb begin
    eff_size = opsz_t'(size);
    if (size == SZ_D && !ext) eff_size = SZ_W;
    hi_byte = 1'b0;
    if (ext) begin
      reg_sel = idx;
    end else if (size == SZ_B) begin
      reg_sel = IDXW'(idx[1:0]);
      hi_byte = idx[2];
    end else begin
      reg_sel = IDXW'(idx[2:0]);
    end
  end
endmodule

// File: rtl/alias_read_slice.sv
module alias_read_slice
  import alias_rf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] row,
  input  opsz_t           eff_size,
  input  logic            hi_byte,
  output logic [XLEN-1:0] data
);
  localparam int WBITS = XLEN / 2;

  always_comb begin
    data = '0;
    unique case (eff_size)
      SZ_B: data[7:0] = hi_byte ? row[15:8] : row[7:0];
      SZ_H: data[15:0] = row[15:0];
      SZ_W: data[WBITS-1:0] = row[WBITS-1:0];
      SZ_D: data = row;
    endcase
  end
endmodule

// File: rtl/alias_write_merge.sv
module alias_write_merge
  import alias_rf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_row,
  input  logic [XLEN-1:0] wdata,
  input  opsz_t           eff_size,
  input  logic            hi_byte,
  output logic [XLEN-1:0] new_row
);
  localparam int WBITS = XLEN / 2;

  always_comb begin
    new_row = old_row;
    unique case (eff_size)
      SZ_B: begin
        if (hi_byte) new_row[15:8] = wdata[7:0];
        else         new_row[7:0]  = wdata[7:0];
      end
      SZ_H: new_row[15:0] = wdata[15:0];
      SZ_W: new_row = {{(XLEN-WBITS){1'b0}}, wdata[WBITS-1:0]};
      SZ_D: new_row = wdata;
    endcase
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] rd0_idx,
  input  logic [1:0]              rd0_size,
  input  logic                    rd0_ext,
  output logic [XLEN-1:0]         rd0_data,
  input  logic [$clog2(NREG)-1:0] rd1_idx,
  input  logic [1:0]              rd1_size,
  input  logic                    rd1_ext,
  output logic [XLEN-1:0]         rd1_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [1:0]              wr_size,
  input  logic                    wr_ext,
  input  logic [XLEN-1:0]         wr_data,
  output logic                    stall
);
  localparam int IDXW = $clog2(NREG);
  localparam int NRD  = 2;

  logic [XLEN-1:0] regs  [NREG];
  logic            pend  [NREG];
  opsz_t           plvl  [NREG];

  logic [IDXW-1:0] r_idx  [NRD];
  logic [1:0]      r_size [NRD];
  logic            r_ext  [NRD];
  logic [XLEN-1:0] r_data [NRD];
  logic [IDXW-1:0] r_sel  [NRD];
  opsz_t           r_eff  [NRD];
  logic            r_hi   [NRD];
  logic            r_stl  [NRD];

  assign r_idx[0]  = rd0_idx;
  assign r_size[0] = rd0_size;
  assign r_ext[0]  = rd0_ext;
  assign r_idx[1]  = rd1_idx;
  assign r_size[1] = rd1_size;
  assign r_ext[1]  = rd1_ext;
  assign rd0_data  = r_data[0];
  assign rd1_data  = r_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    alias_decode #(.IDXW(IDXW)) u_dec (
      .idx(r_idx[p]), .size(r_size[p]), .ext(r_ext[p]),
      .reg_sel(r_sel[p]), .eff_size(r_eff[p]), .hi_byte(r_hi[p])
    );
    alias_read_slice #(.XLEN(XLEN)) u_slice (
      .row(regs[r_sel[p]]), .eff_size(r_eff[p]), .hi_byte(r_hi[p]),
      .data(r_data[p])
    );
    assign r_stl[p] = pend[r_sel[p]] && (r_eff[p] > plvl[r_sel[p]]);
  end

  assign stall = r_stl[0] || r_stl[1];

  logic [IDXW-1:0] w_sel;
  opsz_t           w_eff;
  logic            w_hi;
  logic [XLEN-1:0] w_row;

  alias_decode #(.IDXW(IDXW)) u_wdec (
    .idx(wr_idx), .size(wr_size), .ext(wr_ext),
    .reg_sel(w_sel), .eff_size(w_eff), .hi_byte(w_hi)
  );
  alias_write_merge #(.XLEN(XLEN)) u_merge (
    .old_row(regs[w_sel]), .wdata(wr_data), .eff_size(w_eff),
    .hi_byte(w_hi), .new_row(w_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        regs[r] <= '0;
        pend[r] <= 1'b0;
        plvl[r] <= SZ_B;
      end
    end else begin
      if (wr_en) regs[w_sel] <= w_row;
      for (int r = 0; r < NREG; r++) begin
        if (wr_en && w_sel == IDXW'(r)) begin
          if (w_eff == SZ_W || w_eff == SZ_D) begin
            pend[r] <= 1'b0;
          end else begin
            pend[r] <= 1'b1;
            if (!(pend[r] && plvl[r] == SZ_B)) plvl[r] <= w_eff;
          end
        end else if ((r_stl[0] && r_sel[0] == IDXW'(r)) ||
                     (r_stl[1] && r_sel[1] == IDXW'(r))) begin
          pend[r] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  rd0_idx,
  input logic [1:0]  rd0_size,
  input logic        rd0_ext,
  input logic [63:0] rd0_data,
  input logic [3:0]  rd1_idx,
  input logic [1:0]  rd1_size,
  input logic        rd1_ext,
  input logic [63:0] rd1_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [1:0]  wr_size,
  input logic        wr_ext,
  input logic [63:0] wr_data,
  input logic        stall
);
  a_r1_no_stall_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall);

  a_r8_byte_zext0: assert property (@(posedge clk) disable iff (rst)
    rd0_size == 2'b00 |-> rd0_data[63:8] == 56'd0);

  a_r8_half_zext1: assert property (@(posedge clk) disable iff (rst)
    rd1_size == 2'b01 |-> rd1_data[63:16] == 48'd0);

  a_r6_word_clears_top: assert property (@(posedge clk) disable iff (rst)
    (rd0_size == 2'b11 && rd0_ext && $past(wr_en && wr_size == 2'b10 && wr_ext)
     && rd0_idx == $past(wr_idx)) |-> rd0_data[63:32] == 32'd0);

  a_r9_new_value_next: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b11 && wr_ext && rd0_size == 2'b11 && rd0_ext
     && rd0_idx == wr_idx)
    ##1 ($stable(rd0_idx) && $stable(rd0_size) && $stable(rd0_ext))
    |-> rd0_data == $past(wr_data));

  a_r10_stall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (stall && !wr_en)
    ##1 ($stable(rd0_idx) && $stable(rd0_size) && $stable(rd0_ext) &&
         $stable(rd1_idx) && $stable(rd1_size) && $stable(rd1_ext))
    |-> !stall);
endmodule

bind alias_regfile alias_regfile_chk u_chk (.*);

// File: tb/alias_regfile_bench.sv
module alias_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
  logic        rd0_ext = 1'b0, rd1_ext = 1'b0, wr_ext = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0_data, rd1_data;
  logic        stall;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  alias_regfile u_alias_regfile (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [1:0] s, input logic e, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_size = s; wr_ext = e; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int p, input logic [3:0] i, input logic [1:0] s,
                    input logic e, input logic [63:0] exp, input logic exp_stall);
    @(negedge clk);
    if (p == 0) begin rd0_idx = i; rd0_size = s; rd0_ext = e; end
    else        begin rd1_idx = i; rd1_size = s; rd1_ext = e; end
    #1;
    check({tag, " data"}, (p == 0) ? rd0_data : rd1_data, exp);
    check({tag, " stall"}, {63'd0, stall}, {63'd0, exp_stall});
    @(posedge clk); #1;
    if (p == 0) begin rd0_idx = '0; rd0_size = '0; rd0_ext = 1'b0; end
    else        begin rd1_idx = '0; rd1_size = '0; rd1_ext = 1'b0; end
  endtask

  task automatic t_reset;
    rd("R1 reset reg5", 0, 4'd5, 2'b11, 1'b1, 64'd0, 1'b0);
    rd("R1 reset reg15 port1", 1, 4'd15, 2'b11, 1'b1, 64'd0, 1'b0);
  endtask

  task automatic t_full;
    wr(4'd9, 2'b11, 1'b1, 64'h1122334455667788);
    rd("R2 full 64", 0, 4'd9, 2'b11, 1'b1, 64'h1122334455667788, 1'b0);
    rd("R12 R5 port1 word", 1, 4'd9, 2'b10, 1'b1, 64'h0000000055667788, 1'b0);
    wr(4'd2, 2'b11, 1'b0, 64'hFFFFFFFFFFFFFFFF);
    rd("R2 64 w/o ext acts as 32", 0, 4'd2, 2'b11, 1'b1, 64'h00000000FFFFFFFF, 1'b0);
  endtask

  task automatic t_word_zext;
    wr(4'd9, 2'b10, 1'b1, 64'hAAAABBBBCCCCDDDD);
    rd("R6 word zero-extends", 0, 4'd9, 2'b11, 1'b1, 64'h00000000CCCCDDDD, 1'b0);
  endtask

  task automatic t_legacy_bytes;
    wr(4'd1, 2'b11, 1'b1, 64'h0123456789ABCDEF);
    wr(4'd5, 2'b00, 1'b0, 64'h5A);
    wr(4'd9, 2'b00, 1'b0, 64'h33);
    rd("R3 R8 high byte read", 0, 4'd5, 2'b00, 1'b0, 64'h5A, 1'b0);
    rd("R3 low byte idx3 ignored", 1, 4'd1, 2'b00, 1'b0, 64'h33, 1'b0);
    rd("R7 R10 merged wide read stalls", 0, 4'd1, 2'b11, 1'b1, 64'h0123456789AB5A33, 1'b1);
    rd("R10 stall cleared", 0, 4'd1, 2'b11, 1'b1, 64'h0123456789AB5A33, 1'b0);
  endtask

  task automatic t_ext_bytes;
    wr(4'd5, 2'b11, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    wr(4'd5, 2'b00, 1'b1, 64'h12);
    wr(4'd13, 2'b00, 1'b1, 64'h77);
    rd("R4 ext idx5 low byte of reg5", 0, 4'd5, 2'b00, 1'b1, 64'h12, 1'b0);
    rd("R4 reg1 untouched", 1, 4'd1, 2'b11, 1'b1, 64'h0123456789AB5A33, 1'b0);
    rd("R4 reg5 wide", 0, 4'd5, 2'b11, 1'b1, 64'hFFFFFFFFFFFFFF12, 1'b1);
    rd("R4 reg13 byte", 1, 4'd13, 2'b00, 1'b1, 64'h77, 1'b0);
    rd("R4 reg13 wide", 1, 4'd13, 2'b11, 1'b1, 64'h77, 1'b1);
  endtask

  task automatic t_half;
    wr(4'd3, 2'b11, 1'b1, 64'hDEADDEADDEADDEAD);
    wr(4'd11, 2'b01, 1'b0, 64'hBEEF);
    rd("R11 half read no stall", 0, 4'd3, 2'b01, 1'b1, 64'hBEEF, 1'b0);
    rd("R11 high byte no stall", 1, 4'd7, 2'b00, 1'b0, 64'hBE, 1'b0);
    rd("R10 word after half stalls", 0, 4'd3, 2'b10, 1'b0, 64'hDEADBEEF, 1'b1);
    rd("R7 half merge kept top", 0, 4'd3, 2'b11, 1'b1, 64'hDEADDEADDEADBEEF, 1'b0);
  endtask

  task automatic t_clear;
    wr(4'd6, 2'b00, 1'b1, 64'h44);
    wr(4'd6, 2'b10, 1'b1, 64'h99887766);
    rd("R11 full write clears pending", 0, 4'd6, 2'b11, 1'b1, 64'h99887766, 1'b0);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    rd0_idx = 4'd10; rd0_size = 2'b11; rd0_ext = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd10; wr_size = 2'b11; wr_ext = 1'b1; wr_data = 64'hCAFEF00D12345678;
    #1;
    check("R9 old value same cycle", rd0_data, 64'd0);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R9 new value next cycle", rd0_data, 64'hCAFEF00D12345678);
    rd0_idx = '0; rd0_size = '0; rd0_ext = 1'b0;
  endtask

  task automatic t_two_ports;
    wr(4'd12, 2'b00, 1'b1, 64'h01);
    @(negedge clk);
    rd0_idx = 4'd9; rd0_size = 2'b11; rd0_ext = 1'b1;
    rd1_idx = 4'd12; rd1_size = 2'b01; rd1_ext = 1'b1;
    #1;
    check("R12 port0 data", rd0_data, 64'h00000000CCCCDDDD);
    check("R12 port1 data", rd1_data, 64'h01);
    check("R12 stall from port1", {63'd0, stall}, 64'd1);
    @(posedge clk); #1;
    check("R12 stall cleared", {63'd0, stall}, 64'd0);
    rd0_idx = '0; rd0_size = '0; rd0_ext = 1'b0;
    rd1_idx = '0; rd1_size = '0; rd1_ext = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_word_zext();
    t_legacy_bytes();
    t_ext_bytes();
    t_half();
    t_clear();
    t_bypass();
    t_two_ports();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule